// File: doc/BRIEF.md
# Branch Target Buffer

This block supplies a fetch unit with the address to fetch next without waiting for decode. It keeps a small direct-mapped table of branch targets learned from earlier taken branches. Each cycle the current fetch address is looked up. If the table holds a matching entry, the stored target is returned. Fetch is steered to that target only when an external direction predictor also says the branch is taken. In every other case fetch moves on to the sequential address, four bytes further.

When a taken branch resolves, the execution stage writes the branch address and its computed target into the table. That write replaces whatever entry shared the same slot. The direction predictor itself lives outside this block, and the block holds only one way per slot.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every slot is empty, so no lookup address hits until a write has installed an entry.
- R2: The slot is chosen by address bits [IDX_W+1:2] and the remaining upper bits form the tag. A lookup hits only when the slot is valid and its tag equals the upper bits of the lookup address. An address with the same slot bits but different upper bits misses.
- R3: On a hit, `pred_pc` equals the target most recently written for that branch address.
- R4: When `hit` is 1 and `taken_in` is 1, `next_pc` equals `pred_pc`.
- R5: When `hit` is 0 or `taken_in` is 0, `next_pc` equals `lk_pc + 4`.
- R6: A write replaces the tag, target and valid state of its slot. After the write, the earlier occupant of that slot misses and the new branch address hits, from the next cycle on.
- R7: A write and a lookup to the same slot in the same cycle return the contents that were there before the write.
- R8: When `hit` is 0, `pred_pc` is zero.
- R9: Address bits [1:0] take no part in the slot or tag choice. A lookup whose bits [1:0] are 3 hits the entry written with those bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties every slot |
| lk_pc | input | PC_W | Fetch address being looked up |
| taken_in | input | 1 | Direction prediction for the fetched instruction (1 = taken) |
| wr_en | input | 1 | Install or refresh an entry at the next rising edge |
| wr_pc | input | PC_W | Address of the resolved taken branch |
| wr_target | input | PC_W | Target address of that branch |
| hit | output | 1 | A valid slot's tag matches the lookup address |
| pred_pc | output | PC_W | Stored target on a hit, zero otherwise |
| next_pc | output | PC_W | Address to fetch next |

## Verification
The checker watches the next-address choice on every cycle. It confirms that a hit predicted taken yields the stored target, that every other combination yields the sequential address, and that a miss reports a zero target. It also confirms that a lookup repeating the address written in the previous cycle hits with that target. Behaviours that depend on the history of the table can only be shown by the bench's scenarios: the empty table after reset, aliasing between addresses that share a slot, eviction of an earlier occupant, old contents returned during a same-cycle write, and the ignored low address bits. To show them, the bench fills every slot, sweeps each one with both prediction values, and then drives these cases explicitly.

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            taken_in,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  output logic            hit,
  output logic [PC_W-1:0] pred_pc,
  output logic [PC_W-1:0] next_pc
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [SLOTS-1:0]  slot_vld;
  logic [TAG_W-1:0]  slot_tag [SLOTS];
  logic [PC_W-1:0]   slot_tgt [SLOTS];

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  rd_tag, wr_tag;

  assign rd_idx = lk_pc[IDX_W+1:2];
  assign rd_tag = lk_pc[PC_W-1:IDX_W+2];
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slot_vld <= '0;
    else if (wr_en)
      slot_vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_tag[wr_idx] <= wr_tag;
      slot_tgt[wr_idx] <= wr_target;
    end
  end

  assign hit     = slot_vld[rd_idx] && (slot_tag[rd_idx] == rd_tag);
  assign pred_pc = hit ? slot_tgt[rd_idx] : '0;
  assign next_pc = (hit && taken_in) ? pred_pc : lk_pc + PC_W'(4);
endmodule

module branch_target_buffer_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            taken_in,
  input logic            wr_en,
  input logic [PC_W-1:0] wr_pc,
  input logic [PC_W-1:0] wr_target,
  input logic            hit,
  input logic [PC_W-1:0] pred_pc,
  input logic [PC_W-1:0] next_pc
);
  // R4
  redirect_on_taken_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && taken_in) |-> (next_pc == pred_pc));

  // R5
  sequential_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && taken_in) |-> (next_pc == lk_pc + PC_W'(4)));

  // R8
  zero_target_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pred_pc == '0));

  // R6
  installed_entry_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((lk_pc != $past(wr_pc)) || (hit && pred_pc == $past(wr_target))));
endmodule

bind branch_target_buffer branch_target_buffer_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_branch_target_buffer.sv
`timescale 1ns/100ps
module tb_branch_target_buffer;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int SLOTS = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            taken_in = 1'b0;
  logic            wr_en = 1'b0;
  logic [PC_W-1:0] wr_pc = '0;
  logic [PC_W-1:0] wr_target = '0;
  logic            hit;
  logic [PC_W-1:0] pred_pc;
  logic [PC_W-1:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  branch_target_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [PC_W-1:0] mk_pc(int tag, int idx);
    return (PC_W'(tag) << (IDX_W + 2)) | (PC_W'(idx) << 2);
  endfunction

  function automatic logic [PC_W-1:0] mk_tgt(int tag, int idx);
    return 32'h1000_0000 + PC_W'(tag) * 32'h1_0000 + PC_W'(idx) * 32'h40 + 32'h8;
  endfunction

  task automatic chk(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt);
    @(negedge clk);
    wr_en = 1'b1; wr_pc = pc; wr_target = tgt;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc, logic tk,
                      logic exp_hit, logic [PC_W-1:0] exp_tgt);
    logic [PC_W-1:0] exp_next;
    @(negedge clk);
    lk_pc = pc; taken_in = tk;
    #1;
    exp_next = (exp_hit && tk) ? exp_tgt : pc + 32'd4;
    chk(req, PC_W'(hit), PC_W'(exp_hit));
    chk(req, pred_pc, exp_hit ? exp_tgt : '0);
    chk(req, next_pc, exp_next);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R8: empty after reset, every slot with both predictions
    for (int i = 0; i < SLOTS; i++) begin
      look("R1", mk_pc(5, i), 1'b1, 1'b0, '0);
      look("R8", mk_pc(9, i), 1'b0, 1'b0, '0);
    end

    for (int i = 0; i < SLOTS; i++) do_write(mk_pc(1, i), mk_tgt(1, i));

    // R3 R4 R5: sweep every slot with taken and not taken
    for (int i = 0; i < SLOTS; i++) begin
      look("R3_R4", mk_pc(1, i), 1'b1, 1'b1, mk_tgt(1, i));
      look("R3_R5", mk_pc(1, i), 1'b0, 1'b1, mk_tgt(1, i));
    end

    // R2: same slot, different tag misses
    for (int i = 0; i < SLOTS; i++) look("R2", mk_pc(2, i), 1'b1, 1'b0, '0);
    look("R2", mk_pc(1, 0) | 32'h8000_0000, 1'b1, 1'b0, '0);

    // R9: low address bits ignored
    for (int i = 0; i < SLOTS; i++) look("R9", mk_pc(1, i) | 32'h3, 1'b1, 1'b1, mk_tgt(1, i));

    // R6: overwrite slot 5 with a different tag
    do_write(mk_pc(3, 5), mk_tgt(3, 5));
    look("R6", mk_pc(1, 5), 1'b1, 1'b0, '0);
    look("R6", mk_pc(3, 5), 1'b1, 1'b1, mk_tgt(3, 5));
    look("R6", mk_pc(1, 6), 1'b1, 1'b1, mk_tgt(1, 6));
    // refresh target for same branch
    do_write(mk_pc(3, 5), 32'h2222_0040);
    look("R6", mk_pc(3, 5), 1'b1, 1'b1, 32'h2222_0040);

    // R7: same-cycle write and lookup see old contents, new after the edge
    @(negedge clk);
    lk_pc = mk_pc(3, 5); taken_in = 1'b1;
    wr_en = 1'b1; wr_pc = mk_pc(3, 5); wr_target = 32'h3333_0080;
    #1;
    chk("R7", PC_W'(hit), 32'd1);
    chk("R7", pred_pc, 32'h2222_0040);
    chk("R7", next_pc, 32'h2222_0040);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7", pred_pc, 32'h3333_0080);
    // R7: same-cycle write evicting the looked-up entry still hits old
    @(negedge clk);
    lk_pc = mk_pc(1, 7); taken_in = 1'b1;
    wr_en = 1'b1; wr_pc = mk_pc(4, 7); wr_target = 32'h4444_0000;
    #1;
    chk("R7", PC_W'(hit), 32'd1);
    chk("R7", pred_pc, mk_tgt(1, 7));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7", PC_W'(hit), 32'd0);
    chk("R7", next_pc, mk_pc(1, 7) + 32'd4);

    // R1: reset empties the table again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SLOTS; i++) look("R1", mk_pc(1, i), 1'b1, 1'b0, '0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule